// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation-cache miss by fetching mappings from a two-level page table in memory. A miss request carries a 32-bit virtual address. The walker splits the address into a 10-bit top-table index (bits 31:22), a 10-bit leaf-table index (bits 21:12) and a 12-bit page offset (bits 11:0). It reads the top-table entry through a root base register, and then reads the selected leaf-table entry. The result is either a usable entry that the translation cache can load, or a page-fault indication.

The top table fills exactly one 4 KB page of 1024 four-byte entries. Every entry has the same fixed format. Bit 0 is the present flag, 1 meaning valid. Bits 31:12 hold the page frame number. A top entry that is not present ends the walk after a single memory read and reports the whole 4 MB region as absent. A full walk costs two memory reads.

Miss requests enter on a valid/ready handshake. A request transfers only when `miss_valid` and `miss_ready` are both high at a clock edge. `miss_ready` is high only while the walker is idle. Results leave on a valid/ready handshake as well. Once `res_valid` rises, the result is held unchanged until `res_ready` is seen high, so the consumer may stall for any number of cycles. The memory side is a one-cycle read request strobe with an address, answered by a response strobe with data after any number of wait cycles.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle. In that state `miss_ready`=1, `res_valid`=0, `mem_req`=0, and the root base register reads as 0. Whenever `miss_ready` is high, neither `mem_req` nor `res_valid` is high.
- R2: The cycle after a request is accepted, `mem_req` is high for exactly one cycle. In that cycle `mem_addr` = root base + 4 × vaddr[31:22].
- R3: If the top entry has bit 0 = 0, no second read is issued. The walker returns `res_fault`=1 with `res_pte` equal to that top entry.
- R4: If the top entry has bit 0 = 1, the cycle after its response brings a one-cycle `mem_req`. Its address is {top entry[31:12], 12'h000} + 4 × vaddr[21:12].
- R5: If the leaf entry has bit 0 = 1, the result is `res_fault`=0 and `res_pte` equals the leaf entry.
- R6: If the leaf entry has bit 0 = 0, the result is `res_fault`=1 and `res_pte` equals the leaf entry.
- R7: Any number of wait cycles may come before a memory response. A `mem_rvalid` arriving while no read is outstanding has no effect.
- R8: Requests are accepted only in the idle state. `miss_ready` stays 0 from acceptance until the result has been taken.
- R9: While `res_valid`=1 and `res_ready`=0, `res_valid`, `res_pte` and `res_fault` hold their values. The cycle after `res_ready` is seen high, the walker is idle again.
- R10: A root base write takes effect only for requests accepted in a later cycle. This holds when the write falls during a walk, and also when it falls in the same cycle as an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Root base register write strobe |
| base_wdata | input | 32 | New root base (byte address of the top table) |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Walker can accept a request (idle) |
| miss_vaddr | input | 32 | Virtual address of the miss |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | 32 | Memory read response data |
| res_valid | output | 1 | Walk result available |
| res_ready | input | 1 | Consumer takes the result |
| res_fault | output | 1 | 1 = page fault, 0 = valid entry |
| res_pte | output | 32 | Last entry read by the walk |

## Verification
Two events can fall in the same cycle: a root base write and the acceptance of a miss request. The bench raises `base_we` on the same edge that `miss_valid` is taken. It then checks that the top-table address of that walk was formed from the old base. It also checks that the following walk uses the new base. A second overlap is a stray memory response arriving while the walker is idle. The bench pulses `mem_rvalid` in that state and judges at the ports that the walker stays ready with no result and no request.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_TOP_RD,
    WK_TOP_WT,
    WK_LEAF_RD,
    WK_LEAF_WT,
    WK_DONE
  } walk_state_t;
endpackage

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic mem_rvalid,
  input  logic entry_present,
  input  logic res_ready,
  output logic miss_ready,
  output logic accept,
  output logic mem_req,
  output logic leaf_phase,
  output logic top_load,
  output logic leaf_load,
  output logic res_valid
);
  walk_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WK_IDLE:    if (miss_valid) state_d = WK_TOP_RD;
      WK_TOP_RD:  state_d = WK_TOP_WT;
      WK_TOP_WT:  if (mem_rvalid) state_d = entry_present ? WK_LEAF_RD : WK_DONE;
      WK_LEAF_RD: state_d = WK_LEAF_WT;
      WK_LEAF_WT: if (mem_rvalid) state_d = WK_DONE;
      WK_DONE:    if (res_ready) state_d = WK_IDLE;
      default:    state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WK_IDLE;
    else        state_q <= state_d;
  end

  assign miss_ready = (state_q == WK_IDLE);
  assign accept     = miss_ready && miss_valid;
  assign mem_req    = (state_q == WK_TOP_RD) || (state_q == WK_LEAF_RD);
  assign leaf_phase = (state_q == WK_LEAF_RD);
  assign top_load   = (state_q == WK_TOP_WT) && mem_rvalid;
  assign leaf_load  = (state_q == WK_LEAF_WT) && mem_rvalid;
  assign res_valid  = (state_q == WK_DONE);
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int TOP_IDX_W  = 10,
  parameter int LEAF_IDX_W = 10,
  parameter int PG_OFF_W   = 12,
  parameter int FRAME_W    = 20,
  parameter int PA_W       = 32,
  parameter int IDX_SHIFT  = 2
) (
  input  logic [PA_W-1:0]       root_base,
  input  logic [TOP_IDX_W-1:0]  top_idx,
  input  logic [LEAF_IDX_W-1:0] leaf_idx,
  input  logic [FRAME_W-1:0]    leaf_frame,
  input  logic                  sel_leaf,
  output logic [PA_W-1:0]       entry_addr
);
  logic [PA_W-1:0] top_addr, leaf_addr, leaf_base;

  assign leaf_base  = PA_W'(leaf_frame) << PG_OFF_W;
  assign top_addr   = root_base + (PA_W'(top_idx) << IDX_SHIFT);
  assign leaf_addr  = leaf_base + (PA_W'(leaf_idx) << IDX_SHIFT);
  assign entry_addr = sel_leaf ? leaf_addr : top_addr;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W        = 32,
  parameter int TOP_IDX_W   = 10,
  parameter int LEAF_IDX_W  = 10,
  parameter int ENTRY_W     = 32,
  parameter int PA_W        = 32,
  parameter int ENTRY_BYTES = 4,
  parameter int PRESENT_BIT = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_we,
  input  logic [PA_W-1:0]    base_wdata,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [VA_W-1:0]    miss_vaddr,
  output logic               mem_req,
  output logic [PA_W-1:0]    mem_addr,
  input  logic               mem_rvalid,
  input  logic [ENTRY_W-1:0] mem_rdata,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_fault,
  output logic [ENTRY_W-1:0] res_pte
);
  localparam int PG_OFF_W  = VA_W - TOP_IDX_W - LEAF_IDX_W;
  localparam int FRAME_W   = ENTRY_W - PG_OFF_W;
  localparam int IDX_SHIFT = $clog2(ENTRY_BYTES);

  logic                  accept, top_load, leaf_load, leaf_phase;
  logic                  present;
  logic [PA_W-1:0]       base_q, walk_base_q;
  logic [TOP_IDX_W-1:0]  top_idx_q;
  logic [LEAF_IDX_W-1:0] leaf_idx_q;
  logic [FRAME_W-1:0]    frame_q;
  logic                  fault_q;
  logic [ENTRY_W-1:0]    pte_q;
  logic                  unused_offset;

  assign unused_offset = ^miss_vaddr[PG_OFF_W-1:0];
  assign present       = mem_rdata[PRESENT_BIT];

  pt_walk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .mem_rvalid    (mem_rvalid),
    .entry_present (present),
    .res_ready     (res_ready),
    .miss_ready    (miss_ready),
    .accept        (accept),
    .mem_req       (mem_req),
    .leaf_phase    (leaf_phase),
    .top_load      (top_load),
    .leaf_load     (leaf_load),
    .res_valid     (res_valid)
  );

  pt_addr_gen #(
    .TOP_IDX_W  (TOP_IDX_W),
    .LEAF_IDX_W (LEAF_IDX_W),
    .PG_OFF_W   (PG_OFF_W),
    .FRAME_W    (FRAME_W),
    .PA_W       (PA_W),
    .IDX_SHIFT  (IDX_SHIFT)
  ) u_addr (
    .root_base  (walk_base_q),
    .top_idx    (top_idx_q),
    .leaf_idx   (leaf_idx_q),
    .leaf_frame (frame_q),
    .sel_leaf   (leaf_phase),
    .entry_addr (mem_addr)
  );

  // Root base register; a walk runs on its own snapshot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_base_q <= '0;
      top_idx_q   <= '0;
      leaf_idx_q  <= '0;
    end else if (accept) begin
      walk_base_q <= base_q;
      top_idx_q   <= miss_vaddr[VA_W-1 -: TOP_IDX_W];
      leaf_idx_q  <= miss_vaddr[PG_OFF_W +: LEAF_IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      fault_q <= 1'b0;
      pte_q   <= '0;
    end else if (top_load || leaf_load) begin
      pte_q   <= mem_rdata;
      fault_q <= !present;
      if (top_load) frame_q <= mem_rdata[ENTRY_W-1 -: FRAME_W];
    end
  end

  assign res_fault = fault_q;
  assign res_pte   = pte_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        miss_valid,
  input logic        miss_ready,
  input logic        mem_req,
  input logic        res_valid,
  input logic        res_ready,
  input logic        res_fault,
  input logic [31:0] res_pte
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> (!mem_req && !res_valid));

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R8
  accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (!miss_ready && mem_req));

  // R7
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_ready && !miss_valid) |=> miss_ready);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pte) && $stable(res_fault)));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_valid (miss_valid),
  .miss_ready (miss_ready),
  .mem_req    (mem_req),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_fault  (res_fault),
  .res_pte    (res_pte)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_vaddr = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_fault;
  logic [31:0] res_pte;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vaddr(miss_vaddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .res_ready(res_ready),
    .res_fault(res_fault), .res_pte(res_pte)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  // One complete walk with its memory responses and result checks.
  task automatic run_walk(input logic [31:0] va, input logic [31:0] exp_base,
                          input logic [31:0] top_ent, input logic [31:0] leaf_ent,
                          input int d1, input int d2, input int hold,
                          input bit wr_base, input logic [31:0] new_base);
    logic [31:0] exp_pte;
    logic        exp_fault;
    logic [31:0] a;
    @(negedge clk);
    check(miss_ready == 1'b1, "R8 ready when idle", {31'd0, miss_ready}, 32'd1);
    miss_vaddr = va; miss_valid = 1'b1;
    if (wr_base) begin base_we = 1'b1; base_wdata = new_base; end
    @(negedge clk);
    miss_valid = 1'b0; base_we = 1'b0;
    a = exp_base + {20'd0, va[31:22], 2'b00};
    check(mem_req == 1'b1, "R2 top read strobe", {31'd0, mem_req}, 32'd1);
    check(mem_addr == a, "R2/R10 top entry address", mem_addr, a);
    @(negedge clk);
    check(mem_req == 1'b0, "R2 strobe lasts one cycle", {31'd0, mem_req}, 32'd0);
    check(miss_ready == 1'b0, "R8 busy during walk", {31'd0, miss_ready}, 32'd0);
    repeat (d1) @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = top_ent;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = '0;
    if (top_ent[0]) begin
      a = {top_ent[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
      check(mem_req == 1'b1, "R4 leaf read strobe", {31'd0, mem_req}, 32'd1);
      check(mem_addr == a, "R4 leaf entry address", mem_addr, a);
      @(negedge clk);
      repeat (d2) @(negedge clk);
      mem_rvalid = 1'b1; mem_rdata = leaf_ent;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = '0;
      exp_pte = leaf_ent; exp_fault = !leaf_ent[0];
    end else begin
      check(mem_req == 1'b0, "R3 no leaf read", {31'd0, mem_req}, 32'd0);
      exp_pte = top_ent; exp_fault = 1'b1;
    end
    check(res_valid == 1'b1, "R5/R6 result valid", {31'd0, res_valid}, 32'd1);
    check(res_fault == exp_fault,
          top_ent[0] ? (exp_fault ? "R6 leaf fault" : "R5 no fault") : "R3 top fault",
          {31'd0, res_fault}, {31'd0, exp_fault});
    check(res_pte == exp_pte, top_ent[0] ? "R5/R6 entry returned" : "R3 entry returned",
          res_pte, exp_pte);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(res_valid && res_pte == exp_pte && res_fault == exp_fault,
            "R9 result held", res_pte, exp_pte);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(miss_ready && !res_valid, "R9 idle after take", {31'd0, miss_ready}, 32'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(miss_ready == 1'b1, "R1 ready after reset", {31'd0, miss_ready}, 32'd1);
    check(!res_valid && !mem_req, "R1 quiet after reset", {31'd0, res_valid}, 32'd0);
    // base reads as zero: first walk uses base 0
    run_walk(32'h0040_5000, 32'h0, 32'h0000_0000, 32'h0, 0, 0, 0, 1'b0, 32'h0);
  endtask

  task automatic t_full_hit;
    set_base(32'h0010_0000);
    run_walk(32'h0001_8007, 32'h0010_0000, 32'h0020_0001, 32'h0014_8003, 0, 0, 0, 1'b0, 32'h0);
    run_walk(32'hABCD_E123, 32'h0010_0000, 32'h7777_7001, 32'h1234_5001, 1, 4, 0, 1'b0, 32'h0);
  endtask

  task automatic t_top_fault;
    run_walk(32'hFFC0_1234, 32'h0010_0000, 32'h0030_0000, 32'h0, 3, 0, 0, 1'b0, 32'h0);
  endtask

  task automatic t_leaf_fault;
    run_walk(32'h003F_F000, 32'h0010_0000, 32'h0050_0003, 32'h0014_8000, 5, 2, 0, 1'b0, 32'h0);
  endtask

  task automatic t_stray_response;
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_B001;
    repeat (2) @(negedge clk);
    mem_rvalid = 1'b0;
    check(miss_ready && !res_valid && !mem_req, "R7 stray response ignored",
          {31'd0, miss_ready}, 32'd1);
    run_walk(32'h0080_2000, 32'h0010_0000, 32'h0060_0001, 32'h0099_9001, 7, 6, 0, 1'b0, 32'h0);
  endtask

  task automatic t_backpressure;
    run_walk(32'h1234_5678, 32'h0010_0000, 32'h0070_0001, 32'h0088_8001, 0, 1, 4, 1'b0, 32'h0);
  endtask

  task automatic t_base_collision;
    // R10: write lands with acceptance; this walk keeps the old base
    run_walk(32'h0100_0000, 32'h0010_0000, 32'h0000_0000, 32'h0, 0, 0, 0, 1'b1, 32'h0020_0000);
    run_walk(32'h0100_0000, 32'h0020_0000, 32'h0000_0000, 32'h0, 0, 0, 0, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_hit();
    t_top_fault();
    t_leaf_fault();
    t_stray_response();
    t_backpressure();
    t_base_collision();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule